// File: doc/BRIEF.md
# Configurable registered fan-out buffer

This block is a clocked register bank for the command/address path of a memory module. Two static strap inputs choose how the inputs reach the outputs. In the direct mode, each of the 25 inputs is registered onto its own output position. In the fan-out mode, 14 inputs are registered and each one drives the same position in two output banks. A second strap picks which 14-input window feeds the banks in fan-out mode, and in what bit order.

Two active-low select inputs control the data registers. The data registers load on a rising clock edge only when at least one select is low. When both selects are high, the data registers keep their contents. The registered selects are passed to their own outputs on every active edge, and the select gating does not apply to them.

An active-low reset clears every register at once, without waiting for the clock. While reset is low, every output is low. Reset release is synchronised to the clock. The first rising edge after release captures nothing, so the outputs stay low through that edge and cannot glitch.

Top module: `cmd_fanout_reg`

## Requirements
- R1: While rst_n is low, q_bank0, q_bank1 and sel_q_n are all zero, without waiting for a clock edge.
- R2: After rst_n rises, the first rising clock edge leaves every output at zero whatever the inputs are. The second rising edge is the first that loads data.
- R3: With strap_fanout=0, a loading edge sets q_bank0[i]=din[i] for i in 0..13 and q_bank1[j]=din[14+j] for j in 0..10.
- R4: With strap_fanout=0, q_bank1[13:11] read zero at all times.
- R5: With strap_fanout=1 and strap_upper=0, a loading edge sets q_bank0[i]=q_bank1[i]=din[i] for i in 0..13. din[24:14] has no effect.
- R6: With strap_fanout=1 and strap_upper=1, a loading edge sets q_bank0[i]=q_bank1[i]=din[24-i] for i in 0..13, so din[24] appears at bit 0.
- R7: When both sel_n bits are 2'b11 at a rising edge, q_bank0 and q_bank1 keep their previous values.
- R8: When sel_n is 2'b00, 2'b01 or 2'b10 at a rising edge, the data registers load.
- R9: Every rising edge after the first post-reset edge copies sel_n into sel_q_n, whatever the value of sel_n.
- R10: With strap_fanout=0, strap_upper has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fanout | input | 1 | Mode strap: 0 = direct 25-bit, 1 = 14-bit fan-out to two banks |
| strap_upper | input | 1 | Fan-out window strap: 0 = low window in order, 1 = high window reversed |
| sel_n | input | CS_W (2) | Active-low selects; data loads when any bit is low |
| din | input | WIDE_W (25) | Data inputs |
| q_bank0 | output | NARROW_W (14) | Registered output bank 0 |
| q_bank1 | output | NARROW_W (14) | Registered output bank 1 (upper direct bits or fan-out copy) |
| sel_q_n | output | CS_W (2) | Registered selects, never gated |

## Verification
The bench builds the block with its default parameters: WIDE_W=25, NARROW_W=14 and CS_W=2. With these values bank 1 has three spare positions in direct mode. The two fan-out windows also overlap on inputs 11 to 13, so a misrouted or unreversed bit in either window shows up at the outputs. Random data and select patterns run in each strap setting, with about a quarter of the cycles deselected. Directed cases add single-bit and upper-only inputs, a mode change while deselected, and an asynchronous reset applied between clock edges.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

  typedef enum logic [1:0] {
    MAP_DIRECT = 2'd0,
    MAP_LOW    = 2'd1,
    MAP_HIGH   = 2'd2
  } map_mode_e;

  function automatic map_mode_e decode_straps(input logic fanout, input logic upper);
    if (!fanout) return MAP_DIRECT;
    return upper ? MAP_HIGH : MAP_LOW;
  endfunction

  function automatic logic route_bit(input map_mode_e m, input logic lo_bit,
                                     input logic hi_bit, input logic direct_bit);
    case (m)
      MAP_DIRECT: return direct_bit;
      MAP_LOW:    return lo_bit;
      MAP_HIGH:   return hi_bit;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fanout_arm.sv
module fanout_arm (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end
endmodule

// File: rtl/fanout_route.sv
module fanout_route
  import fanout_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic [WIDE_W-1:0]   din,
  input  map_mode_e           mode,
  output logic [NARROW_W-1:0] bank0,
  output logic [NARROW_W-1:0] bank1
);
  localparam int DIRECT_HI_W = WIDE_W - NARROW_W;

  for (genvar i = 0; i < NARROW_W; i++) begin : g_bit
    localparam int HI_IDX = WIDE_W - 1 - i;
    logic direct_hi;
    if (i < DIRECT_HI_W) begin : g_used
      assign direct_hi = din[NARROW_W + i];
    end else begin : g_spare
      assign direct_hi = 1'b0;
      always_comb begin
        if (mode == MAP_DIRECT) begin
          assert_spare_route_R4: assert (bank1[i] == 1'b0)
            else $error("spare bank1 bit %0d routed non-zero in direct mode", i);
        end
      end
    end
    assign bank0[i] = route_bit(mode, din[i], din[HI_IDX], din[i]);
    assign bank1[i] = route_bit(mode, din[i], din[HI_IDX], direct_hi);
  end
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q))
    else $error("register changed while disabled");

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d)))
    else $error("register missed a load");
endmodule

// File: rtl/cmd_fanout_reg.sv
module cmd_fanout_reg
  import fanout_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strap_fanout,
  input  logic                strap_upper,
  input  logic [CS_W-1:0]     sel_n,
  input  logic [WIDE_W-1:0]   din,
  output logic [NARROW_W-1:0] q_bank0,
  output logic [NARROW_W-1:0] q_bank1,
  output logic [CS_W-1:0]     sel_q_n
);
  localparam int BANK_W      = 2 * NARROW_W;
  localparam int DIRECT_HI_W = WIDE_W - NARROW_W;

  function automatic logic [NARROW_W-1:0] spare_mask_f();
    logic [NARROW_W-1:0] m;
    for (int i = 0; i < NARROW_W; i++) m[i] = (i >= DIRECT_HI_W);
    return m;
  endfunction

  localparam logic [NARROW_W-1:0] SPARE_MASK = spare_mask_f();

  map_mode_e           mode;
  logic                armed;
  logic                any_sel;
  logic                data_en;
  logic [NARROW_W-1:0] next0;
  logic [NARROW_W-1:0] next1;
  logic [BANK_W-1:0]   bank_q;

  assign mode    = decode_straps(strap_fanout, strap_upper);
  assign any_sel = ~(&sel_n);
  assign data_en = armed & any_sel;

  fanout_arm u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed)
  );

  fanout_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_route (
    .din   (din),
    .mode  (mode),
    .bank0 (next0),
    .bank1 (next1)
  );

  hold_reg #(.W(BANK_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (data_en),
    .d     ({next1, next0}),
    .q     (bank_q)
  );

  hold_reg #(.W(CS_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (armed),
    .d     (sel_n),
    .q     (sel_q_n)
  );

  assign q_bank0 = bank_q[NARROW_W-1:0];
  assign q_bank1 = bank_q[BANK_W-1:NARROW_W] & ~((mode == MAP_DIRECT) ? SPARE_MASK : '0);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (q_bank0 == '0 && q_bank1 == '0 && sel_q_n == '0)
        else $error("outputs not low during reset");
    end
  end

  assert_first_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (q_bank0 == '0 && q_bank1 == '0 && sel_q_n == '0))
    else $error("output moved on first edge after reset release");

  assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && mode == MAP_DIRECT) |=> (q_bank0 == $past(din[NARROW_W-1:0])))
    else $error("direct mode bank0 mismatch");

  assert_spare_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_fanout |-> ((q_bank1 & SPARE_MASK) == '0))
    else $error("spare outputs high in direct mode");

  assert_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && strap_fanout) |=> (!strap_fanout || q_bank0 == q_bank1))
    else $error("fan-out banks differ");

  assert_reverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && mode == MAP_HIGH) |=> (q_bank0[0] == $past(din[WIDE_W-1])))
    else $error("high window bit order wrong");

  assert_sel_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (sel_q_n == $past(sel_n)))
    else $error("select pass-through mismatch");
endmodule

// File: tb/sim_cmd_fanout_reg.sv
module sim_cmd_fanout_reg;
  localparam int WIDE_W   = 25;
  localparam int NARROW_W = 14;
  localparam int CS_W     = 2;
  localparam int OUT_W    = 2 * NARROW_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strap_fanout = 1'b0;
  logic              strap_upper = 1'b0;
  logic [CS_W-1:0]   sel_n = '1;
  logic [WIDE_W-1:0] din = '0;
  logic [NARROW_W-1:0] q_bank0, q_bank1;
  logic [CS_W-1:0]   sel_q_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [OUT_W-1:0] exp_bank = '0;
  logic [CS_W-1:0]  exp_sel = '0;

  cmd_fanout_reg #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CS_W(CS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_fanout(strap_fanout), .strap_upper(strap_upper),
    .sel_n(sel_n), .din(din), .q_bank0(q_bank0), .q_bank1(q_bank1), .sel_q_n(sel_q_n)
  );

  always #4 clk = ~clk;

  function automatic logic [OUT_W-1:0] expect_map(input logic [WIDE_W-1:0] d,
                                                   input logic fan, input logic up);
    logic [OUT_W-1:0] r;
    for (int p = 0; p < OUT_W; p++) begin
      int k;
      k = p % NARROW_W;
      if (!fan)     r[p] = (p < WIDE_W) ? d[p] : 1'b0;
      else if (!up) r[p] = d[k];
      else          r[p] = d[WIDE_W - 1 - k];
    end
    return r;
  endfunction

  function automatic logic [OUT_W-1:0] visible(input logic [OUT_W-1:0] b, input logic fan);
    logic [OUT_W-1:0] r;
    r = b;
    if (!fan) for (int p = WIDE_W; p < OUT_W; p++) r[p] = 1'b0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " banks"}, 64'({q_bank1, q_bank0}), 64'(visible(exp_bank, strap_fanout)));
    check("R9 select pass-through", 64'(sel_q_n), 64'(exp_sel));
    if (!strap_fanout) check("R4 spare bits low", 64'(q_bank1[NARROW_W-1:WIDE_W-NARROW_W]), 64'(0));
  endtask

  task automatic step(input logic [WIDE_W-1:0] d, input logic [CS_W-1:0] s,
                      input logic fan, input logic up, input string tag);
    @(negedge clk);
    din = d; sel_n = s; strap_fanout = fan; strap_upper = up;
    @(posedge clk);
    if (s != '1) exp_bank = expect_map(d, fan, up);
    exp_sel = s;
    #1;
    check_outputs((s == '1) ? "R7 deselected hold" : tag);
  endtask

  task automatic release_and_arm(input logic [WIDE_W-1:0] d, input logic fan, input logic up);
    @(negedge clk);
    rst_n = 1'b1; din = d; sel_n = '0; strap_fanout = fan; strap_upper = up;
    @(posedge clk); #1;
    check("R2 first edge after release", 64'({sel_q_n, q_bank1, q_bank0}), 64'(0));
    @(posedge clk);
    exp_bank = expect_map(d, fan, up);
    exp_sel = '0;
    #1;
    check_outputs("R2 second edge loads");
  endtask

  function automatic logic [CS_W-1:0] rand_sel();
    logic [CS_W-1:0] s;
    s = CS_W'($urandom_range(0, 3));
    return s;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; din = '1; sel_n = '0; strap_fanout = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R1 outputs low in reset", 64'({sel_q_n, q_bank1, q_bank0}), 64'(0));
    end
    release_and_arm(25'h155_5AA5, 1'b0, 1'b0);

    for (int i = 0; i < 60; i++)
      step(WIDE_W'($urandom), rand_sel(), 1'b0, 1'($urandom), "R3 R10 R8 direct");

    step(25'h1FF_FFFF, 2'b01, 1'b0, 1'b1, "R4 R10 all ones direct");
    step(25'h000_0000, 2'b10, 1'b0, 1'b0, "R3 zeros direct");

    for (int i = 0; i < 60; i++)
      step(WIDE_W'($urandom), rand_sel(), 1'b1, 1'b0, "R5 R8 fan-out low");
    step(25'h1FF_C000, 2'b00, 1'b1, 1'b0, "R5 upper-only ignored");
    step(25'h000_0001, 2'b01, 1'b1, 1'b0, "R5 single bit");

    for (int i = 0; i < 60; i++)
      step(WIDE_W'($urandom), rand_sel(), 1'b1, 1'b1, "R6 R8 fan-out high");
    step(25'h100_0000, 2'b10, 1'b1, 1'b1, "R6 top bit to bit 0");
    step(25'h000_07FF, 2'b00, 1'b1, 1'b1, "R6 low-only ignored");

    step(25'h0AB_CDEF, 2'b11, 1'b0, 1'b0, "R7 mode change while held");
    step(25'h0AB_CDEF, 2'b00, 1'b0, 1'b0, "R3 load after hold");

    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    check("R1 async clear between edges", 64'({sel_q_n, q_bank1, q_bank0}), 64'(0));
    @(posedge clk); #1;
    check("R1 held in reset", 64'({sel_q_n, q_bank1, q_bank0}), 64'(0));
    release_and_arm(25'h1FF_FFFF, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++)
      step(WIDE_W'($urandom), rand_sel(), 1'b1, 1'b1, "R6 after re-arm");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule